// File: doc/BRIEF.md
# Real-Time Clock Update-Cycle and Interrupt-Flag Controller

This block paces a real-time clock. It divides a base-rate tick into one-second intervals and issues a single-cycle strobe at each rollover, which a separate calendar unit uses to advance the time. Shortly before each rollover it raises an update-in-progress indication. While that indication is high, software knows that the time registers are about to change.

The block also keeps the status and interrupt registers. Software reaches them through an index/data register port. The periodic unit and the alarm unit send event pulses to the block. The block merges those events with its own update-ended event into a flag register and drives one interrupt line. Software controls the rate-select and divider-reset field and the enable bits. Reading the flag register acknowledges every flag at once.

Top module: `rtcu_ctrl`

## Requirements
- R1: A write with `bus_sel_i`=0 loads `wdata_i[6:0]` into the index and drops bit 7. A read or write with `bus_sel_i`=1 reaches the indexed register: control A at 0x0A, control B at 0x0B, flags at 0x0C, status D at 0x0D. Every other index reads 0x00.
- R2: After reset, A reads 0x26, B reads 0x02, the flags read 0x00, D reads 0x80 and `irq_o` is low.
- R3: Bit 7 of A is the update-in-progress bit. It reads 1 only during the last `UIP_HOLD` ticks of each second while the clock runs. A write to bit 7 has no effect.
- R4: When the clock runs, `sec_strobe_o` pulses once every `TICKS_PER_SEC` ticks. The update-ended flag (bit 4 of the flags) is set on the same cycle, and the update-in-progress bit falls on that cycle too.
- R5: When A[6:5]=11 the divider is held in reset. In that state there is no strobe, no update-ended flag, no alarm flag and no update-in-progress bit. A[6:4] values of 3 to 5 also freeze the divider.
- R6: A write that takes A out of divider reset to an A[6:4] value of 2 or less places the first strobe half a second (`TICKS_PER_SEC`/2 ticks) later.
- R7: While B bit 7 (the SET bit) is 1, the update-in-progress bit reads 0 and `sec_strobe_o` stays low.
- R8: `periodic_evt_i` sets flag bit 6, `alarm_evt_i` sets bit 5, and the rollover sets bit 4. The enable bits for those flags are B bits 6, 5 and 4. A flag that becomes newly set while its enable bit is 1 sets bit 7 (the summary flag) and raises `irq_o`.
- R9: A read of the flags returns their current value. The same read then clears all flag bits and lowers `irq_o`.
- R10: A write to B sets the summary flag and raises `irq_o` at once if the new value enables a flag that is already set. Any other write to B clears the summary flag and lowers `irq_o`.
- R11: Writes to the flags register and to D have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Base-rate tick enable |
| bus_sel_i | input | 1 | 0 selects the index, 1 selects the data register |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (has side effects only on the flags) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Contents of the indexed register |
| periodic_evt_i | input | 1 | Periodic event pulse |
| alarm_evt_i | input | 1 | Alarm match pulse |
| sec_strobe_o | output | 1 | One-second advance strobe |
| irq_o | output | 1 | Interrupt request, equal to the summary flag |

## Verification
The bench walks through one whole second, tick by tick. A design whose update-in-progress window is offset by one tick, or whose window does not fall on the strobe cycle, fails that check.

The bench releases the divider from reset and measures the delay to the first strobe. A design that restarts the divider from zero would report a full second instead of a half.

The bench leaves a flag set and then writes an enable bit for it. A design that updates the summary flag only when a new event arrives would never raise the interrupt. The bench also holds the SET bit or the divider reset and sends events during that time, to confirm that the strobe, the update-in-progress bit and the alarm flag stay quiet.

// File: rtl/rtcu_pkg.sv
package rtcu_pkg;
  localparam logic [6:0] IDX_A = 7'h0A;
  localparam logic [6:0] IDX_B = 7'h0B;
  localparam logic [6:0] IDX_C = 7'h0C;
  localparam logic [6:0] IDX_D = 7'h0D;

  localparam int B_SET = 7;

  localparam logic [6:0] A_RST   = 7'h26;
  localparam logic [7:0] B_RST   = 8'h02;
  localparam logic [7:0] D_VALUE = 8'h80;
endpackage

// File: rtl/rtcu_divider.sv
module rtcu_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_HOLD      = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic div_hold_i,
  input  logic div_run_i,
  input  logic set_i,
  input  logic half_load_i,
  output logic uip_o,
  output logic roll_o
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] WIN  = CW'(TICKS_PER_SEC - UIP_HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                cnt <= '0;
    else if (half_load_i)       cnt <= HALF;
    else if (div_hold_i)        cnt <= '0;
    else if (div_run_i && tick_i) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign roll_o = div_run_i && tick_i && (cnt == LAST) && !half_load_i;
  assign uip_o  = div_run_i && !set_i && (cnt >= WIN);
endmodule

// File: rtl/rtcu_flags.sv
module rtcu_flags (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pf_evt_i,
  input  logic       af_evt_i,
  input  logic       uf_evt_i,
  input  logic       clr_i,
  input  logic [2:0] en_i,
  input  logic       bwr_i,
  input  logic [2:0] bwr_en_i,
  output logic [7:0] flags_o
);
  logic [2:0] flg, base, ev, newf, nf;
  logic       irqf, irqf_n;

  always_comb begin
    ev   = {pf_evt_i, af_evt_i, uf_evt_i};
    base = clr_i ? 3'b000 : flg;
    newf = ev & ~base;
    nf   = base | ev;
    if (bwr_i) irqf_n = |(bwr_en_i & nf);
    else       irqf_n = (!clr_i && irqf) || (|(newf & en_i));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flg  <= '0;
      irqf <= 1'b0;
    end else begin
      flg  <= nf;
      irqf <= irqf_n;
    end
  end

  assign flags_o = {irqf, flg, 4'b0000};
endmodule

// File: rtl/rtcu_ctrl.sv
module rtcu_ctrl
  import rtcu_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_HOLD      = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       bus_sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       periodic_evt_i,
  input  logic       alarm_evt_i,
  output logic       sec_strobe_o,
  output logic       irq_o
);
  logic [6:0] idx, a_reg;
  logic [7:0] b_reg, flags;
  logic wr_idx, wr_a, wr_b, clr, div_hold, div_run, half_load, uip, roll, af_gated;

  assign wr_idx    = wr_en_i && !bus_sel_i;
  assign wr_a      = wr_en_i && bus_sel_i && (idx == IDX_A);
  assign wr_b      = wr_en_i && bus_sel_i && (idx == IDX_B);
  assign clr       = rd_en_i && bus_sel_i && (idx == IDX_C);
  assign div_hold  = (a_reg[6:5] == 2'b11);
  assign div_run   = (a_reg[6:4] <= 3'd2);
  assign half_load = wr_a && div_hold && (wdata_i[6:4] <= 3'd2);
  assign af_gated  = alarm_evt_i && !div_hold;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      idx          <= '0;
      a_reg        <= A_RST;
      b_reg        <= B_RST;
      sec_strobe_o <= 1'b0;
    end else begin
      if (wr_idx) idx   <= wdata_i[6:0];
      if (wr_a)   a_reg <= wdata_i[6:0];
      if (wr_b)   b_reg <= wdata_i;
      sec_strobe_o <= roll && !b_reg[B_SET];
    end
  end

  rtcu_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_HOLD(UIP_HOLD)) div_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .div_hold_i(div_hold), .div_run_i(div_run), .set_i(b_reg[B_SET]),
    .half_load_i(half_load), .uip_o(uip), .roll_o(roll)
  );

  rtcu_flags flags_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pf_evt_i(periodic_evt_i), .af_evt_i(af_gated), .uf_evt_i(roll),
    .clr_i(clr), .en_i(b_reg[6:4]), .bwr_i(wr_b), .bwr_en_i(wdata_i[6:4]),
    .flags_o(flags)
  );

  always_comb begin
    case (idx)
      IDX_A:   rdata_o = {uip, a_reg};
      IDX_B:   rdata_o = b_reg;
      IDX_C:   rdata_o = flags;
      IDX_D:   rdata_o = D_VALUE;
      default: rdata_o = 8'h00;
    endcase
  end

  assign irq_o = flags[7];
endmodule

// File: rtl/rtcu_ctrl_chk.sv
module rtcu_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uip,
  input logic       roll,
  input logic       sec_strobe_o,
  input logic       irq_o,
  input logic       clr,
  input logic       periodic_evt_i,
  input logic       af_gated,
  input logic [7:0] flags,
  input logic [6:0] a_reg,
  input logic [7:0] b_reg
);
  // R4
  strobe_after_uip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_strobe_o |-> (!uip && $past(uip)));

  // R5
  div_hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_reg[6:5] == 2'b11) |=> !sec_strobe_o);

  // R7
  set_blocks_uip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_reg[7] |-> !uip);

  // R9
  read_clears_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !periodic_evt_i && !af_gated && !roll) |=> !irq_o);

  // R8
  irq_needs_enabled_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((flags[6:4] & b_reg[6:4]) != 3'b000));
endmodule

bind rtcu_ctrl rtcu_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .uip(uip), .roll(roll),
  .sec_strobe_o(sec_strobe_o), .irq_o(irq_o), .clr(clr),
  .periodic_evt_i(periodic_evt_i), .af_gated(af_gated),
  .flags(flags), .a_reg(a_reg), .b_reg(b_reg)
);

// File: tb/rtcu_ctrl_tb_top.sv
module rtcu_ctrl_tb_top;
  localparam int TPS  = 64;
  localparam int HOLD = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic bus_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic pf = 1'b0, af = 1'b0, strobe, irq;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  rtcu_ctrl #(.TICKS_PER_SEC(TPS), .UIP_HOLD(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_sel_i(bus_sel),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
    .periodic_evt_i(pf), .alarm_evt_i(af), .sec_strobe_o(strobe), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] i, output logic [7:0] v);
    do_wr(1'b0, i);
    #1 v = rdata;
  endtask

  task automatic rd_c(output logic [7:0] v);
    do_wr(1'b0, 8'h0C);
    bus_sel = 1'b1; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic sync_strobe();
    tick = 1'b1;
    for (int n = 0; n < 4 * TPS; n++) begin
      @(negedge clk);
      if (strobe) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(8'h0A, v); check(v == 8'h26, "R2 A", v, 8'h26);
    peek(8'h0B, v); check(v == 8'h02, "R2 B", v, 8'h02);
    peek(8'h0C, v); check(v == 8'h00, "R2 C", v, 8'h00);
    peek(8'h0D, v); check(v == 8'h80, "R2 D", v, 8'h80);
    check(irq == 1'b0, "R2 irq", irq, 0);
  endtask

  task automatic t_uip_second();
    logic [7:0] v;
    int bad = 0;
    peek(8'h0A, v);
    sync_strobe();
    check(strobe && !rdata[7], "R4 uip low at strobe", rdata[7], 0);
    for (int k = 1; k < TPS; k++) begin
      @(negedge clk);
      if (rdata[7] != (k >= TPS - HOLD) || strobe) bad++;
    end
    check(bad == 0, "R3 uip window", bad, 0);
    @(negedge clk);
    tick = 1'b0;
    check(strobe == 1'b1, "R4 strobe period", strobe, 1);
    rd_c(v); check(v == 8'h10, "R4 UF set", v, 8'h10);
    rd_c(v); check(v == 8'h00, "R9 cleared", v, 8'h00);
  endtask

  task automatic t_uie();
    logic [7:0] v;
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h12);
    sync_strobe(); tick = 1'b0;
    check(irq == 1'b1, "R8 UF irq", irq, 1);
    rd_c(v); check(v == 8'h90, "R9 read value", v, 8'h90);
    check(irq == 1'b0, "R9 irq low", irq, 0);
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h02);
  endtask

  task automatic t_pending();
    logic [7:0] v;
    @(negedge clk); pf = 1'b1; @(negedge clk); pf = 1'b0;
    peek(8'h0C, v); check(v == 8'h40 && !irq, "R8 PF no enable", v, 8'h40);
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h42);
    peek(8'h0C, v); check(v == 8'hC0 && irq, "R10 pending fires", v, 8'hC0);
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h02);
    peek(8'h0C, v); check(v == 8'h40 && !irq, "R10 clear", v, 8'h40);
    rd_c(v);
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h22);
    @(negedge clk); af = 1'b1; @(negedge clk); af = 1'b0;
    check(irq == 1'b1, "R8 AF irq", irq, 1);
    rd_c(v); check(v == 8'hA0, "R8 AF value", v, 8'hA0);
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h02);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    do_wr(1'b0, 8'h0A); do_wr(1'b1, 8'hA6);
    peek(8'h0A, v); check(v == 8'h26, "R3 bit7 read-only", v, 8'h26);
    do_wr(1'b0, 8'h0C); do_wr(1'b1, 8'hFF);
    peek(8'h0C, v); check(v == 8'h00, "R11 C write", v, 8'h00);
    do_wr(1'b0, 8'h0D); do_wr(1'b1, 8'h00);
    peek(8'h0D, v); check(v == 8'h80, "R11 D write", v, 8'h80);
    do_wr(1'b0, 8'h8B); do_wr(1'b1, 8'h06);
    peek(8'h0B, v); check(v == 8'h06, "R1 index mask", v, 8'h06);
    do_wr(1'b1, 8'h02);
    peek(8'h05, v); check(v == 8'h00, "R1 unused index", v, 8'h00);
  endtask

  task automatic t_divreset();
    logic [7:0] v;
    int s = 0, u = 0, n = 0;
    do_wr(1'b0, 8'h0A); do_wr(1'b1, 8'h66);
    tick = 1'b1;
    for (int k = 0; k < 2 * TPS; k++) begin
      @(negedge clk);
      af = (k == 10);
      if (strobe) s++;
      if (rdata[7]) u++;
    end
    tick = 1'b0; af = 1'b0;
    check(s == 0 && u == 0, "R5 held quiet", s + u, 0);
    peek(8'h0C, v); check(v == 8'h00, "R5 no flags", v, 8'h00);
    do_wr(1'b0, 8'h0A); do_wr(1'b1, 8'h26);
    tick = 1'b1;
    for (int k = 1; k <= 2 * TPS; k++) begin
      @(negedge clk);
      if (strobe) begin n = k; break; end
    end
    tick = 1'b0;
    check(n == TPS / 2, "R6 half second", n, TPS / 2);
    rd_c(v);
  endtask

  task automatic t_set();
    logic [7:0] v;
    int s = 0, u = 0;
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h82);
    peek(8'h0A, v);
    tick = 1'b1;
    for (int k = 0; k < 2 * TPS; k++) begin
      @(negedge clk);
      if (strobe) s++;
      if (rdata[7]) u++;
    end
    tick = 1'b0;
    check(s == 0 && u == 0, "R7 set mode quiet", s + u, 0);
    do_wr(1'b0, 8'h0B); do_wr(1'b1, 8'h02);
    rd_c(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_uip_second();
    t_uie();
    t_pending();
    t_regs();
    t_divreset();
    t_set();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule